// File: doc/BRIEF.md
# Exception Capture and Vectoring Unit

This unit sits beside the control sequencer of a multicycle processor. It watches two fault conditions: an opcode that the decoder does not recognise, and a signed overflow from the ALU on a register-to-register arithmetic instruction. When it sees a fault in the step where that fault is meaningful, it inserts a one-cycle exception step. In that step it saves the address of the faulting instruction and a cause code, forces the program counter to a fixed handler entry point, and suppresses any register-file write that the sequencer still requests.

The program counter has already been advanced by one instruction when a fault is seen. The saved address is therefore the current PC value minus the instruction size. The cause register is a full data word in which only the lowest bit carries information. The handler address is a single constant that the unit presents as the fourth input of the PC-source multiplexer. The `excStep` output tells the sequencer to return to instruction fetch after the step.

Top module: `exc_unit`

## Requirements
- R1: While reset is asserted and afterwards until the first exception, `epcOut` and `causeOut` read zero and `excStep` is low.
- R2: If `ctrlState` equals the decode-step code (1) and `opValid` is low on a clock edge, `excStep` is high for the following cycle, with `pcSrcOut` = 2'b11 and `pcWriteOut` = 1 during that cycle.
- R3: If `ctrlState` equals the R-type execute-step code (6) and `aluOverflow` is high on a clock edge, the following cycle is an exception step in which `regWriteOut` is 0 even when `regWriteIn` is 1.
- R4: At the end of the exception step, `epcOut` takes the `pcValue` seen during that step minus 4, modulo 2^32 (a PC of 0 saves 0xFFFFFFFC).
- R5: At the end of the exception step, `causeOut` takes 0 for an undefined opcode and 1 for an overflow. Bits 31..1 are always zero.
- R6: The exception step lasts exactly one cycle. A fault indication present during the step itself does not start another step.
- R7: Outside the exception step, `pcSrcOut`, `pcWriteOut` and `regWriteOut` equal `pcSrcIn`, `pcWriteIn` and `regWriteIn`.
- R8: A low `opValid` in any state other than decode, and a high `aluOverflow` in any state other than R-type execute, have no effect: no step occurs and `epcOut` and `causeOut` are unchanged.
- R9: `vectorAddr` always reads 0xC0000000.
- R10: `epcOut` and `causeOut` keep their values in every cycle that is not an exception step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlState | input | 4 | Current state code of the control sequencer |
| opValid | input | 1 | Decoder flag: the opcode is recognised |
| aluOverflow | input | 1 | ALU signed-overflow flag |
| pcValue | input | 32 | Current program counter (already incremented) |
| pcSrcIn | input | 2 | PC-source select requested by the sequencer |
| pcWriteIn | input | 1 | PC write requested by the sequencer |
| regWriteIn | input | 1 | Register-file write requested by the sequencer |
| pcSrcOut | output | 2 | PC-source select after override |
| pcWriteOut | output | 1 | PC write after override |
| regWriteOut | output | 1 | Register-file write after suppression |
| excStep | output | 1 | High during the exception step; the sequencer goes to fetch next |
| vectorAddr | output | 32 | Handler entry address for PC-source input 3 |
| epcOut | output | 32 | Saved faulting instruction address |
| causeOut | output | 32 | Saved cause code |

## Verification
Some properties are checked on every cycle by the assertions. The step never lasts more than one cycle. The multiplexer override and write suppression hold whenever the step is active. A recognised trigger always produces a step. The saved address equals the previous PC minus one instruction. Both registers hold outside the step, and the upper cause bits stay zero. Other behaviour can only be shown by the bench scenarios: a fault flag outside its own state does nothing, the two causes write different codes, the saved address wraps when the PC is zero, and a fault during the step itself is ignored.

// File: rtl/exc_pkg.sv
package exc_pkg;
  // strobes from the exception sequencer to the capture datapath
  typedef struct packed {
    logic epcWrite;
    logic causeWrite;
    logic intCause;     // 0: undefined opcode, 1: overflow
    logic takeVector;
  } excStrobeT;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int STATE_W      = 4,
  parameter int DECODE_STATE = 1,
  parameter int REXEC_STATE  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] ctrlState,
  input  logic               opValid,
  input  logic               aluOverflow,
  output excStrobeT          strobes,
  output logic               excStep
);
  localparam logic [STATE_W-1:0] DecodeCode = STATE_W'(DECODE_STATE);
  localparam logic [STATE_W-1:0] RexecCode  = STATE_W'(REXEC_STATE);

  logic stepQ;
  logic causeQ;
  logic undefHit;
  logic ovfHit;

  assign undefHit = (ctrlState == DecodeCode) && !opValid && !stepQ;
  assign ovfHit   = (ctrlState == RexecCode) && aluOverflow && !stepQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ  <= 1'b0;
      causeQ <= 1'b0;
    end else begin
      stepQ <= undefHit | ovfHit;
      if (undefHit | ovfHit) causeQ <= ovfHit;
    end
  end

  always_comb begin
    strobes.epcWrite   = stepQ;
    strobes.causeWrite = stepQ;
    strobes.intCause   = causeQ;
    strobes.takeVector = stepQ;
  end
  assign excStep = stepQ;

  // R6: the step never extends past one cycle
  assert_single_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    excStep |=> !excStep);

  // R2: an unrecognised opcode in decode leads to a step
  assert_undef_trigger_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == DecodeCode && !opValid && !excStep) |=> excStep);

  // R3: an overflow in R-type execute leads to a step that reports overflow
  assert_ovf_trigger_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == RexecCode && aluOverflow && !excStep) |=> (excStep && strobes.intCause));
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int               XLEN    = 32,
  parameter int               PC_STEP = 4,
  parameter logic [XLEN-1:0]  VECTOR  = 32'hC000_0000
) (
  input  logic            clk,
  input  logic            rstN,
  input  excStrobeT       strobes,
  input  logic [XLEN-1:0] pcValue,
  input  logic [1:0]      pcSrcIn,
  input  logic            pcWriteIn,
  input  logic            regWriteIn,
  output logic [1:0]      pcSrcOut,
  output logic            pcWriteOut,
  output logic            regWriteOut,
  output logic [XLEN-1:0] vectorAddr,
  output logic [XLEN-1:0] epcOut,
  output logic [XLEN-1:0] causeOut
);
  localparam logic [1:0]      SrcVector = 2'b11;
  localparam logic [XLEN-1:0] StepWord  = XLEN'(PC_STEP);

  logic [XLEN-1:0] epcQ;
  logic [XLEN-1:0] causeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      epcQ   <= '0;
      causeQ <= '0;
    end else begin
      if (strobes.epcWrite)   epcQ   <= pcValue - StepWord;
      if (strobes.causeWrite) causeQ <= {{(XLEN-1){1'b0}}, strobes.intCause};
    end
  end

  always_comb begin
    pcSrcOut    = strobes.takeVector ? SrcVector : pcSrcIn;
    pcWriteOut  = strobes.takeVector | pcWriteIn;
    regWriteOut = regWriteIn & ~strobes.takeVector;
  end

  assign vectorAddr = VECTOR;
  assign epcOut     = epcQ;
  assign causeOut   = causeQ;

  // R4: saved address is the previous cycle's PC less one instruction
  assert_epc_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.epcWrite |=> epcOut == $past(pcValue) - StepWord);

  // R5: only the lowest cause bit may ever be set
  assert_cause_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    causeOut[XLEN-1:1] == '0);

  // R10: both registers hold outside the step
  assert_regs_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.epcWrite |=> ($stable(epcOut) && $stable(causeOut)));
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              STATE_W      = 4,
  parameter int              DECODE_STATE = 1,
  parameter int              REXEC_STATE  = 6,
  parameter int              PC_STEP      = 4,
  parameter logic [XLEN-1:0] VECTOR       = 32'hC000_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] ctrlState,
  input  logic               opValid,
  input  logic               aluOverflow,
  input  logic [XLEN-1:0]    pcValue,
  input  logic [1:0]         pcSrcIn,
  input  logic               pcWriteIn,
  input  logic               regWriteIn,
  output logic [1:0]         pcSrcOut,
  output logic               pcWriteOut,
  output logic               regWriteOut,
  output logic               excStep,
  output logic [XLEN-1:0]    vectorAddr,
  output logic [XLEN-1:0]    epcOut,
  output logic [XLEN-1:0]    causeOut
);
  excStrobeT strobes;

  exc_ctrl #(
    .STATE_W(STATE_W), .DECODE_STATE(DECODE_STATE), .REXEC_STATE(REXEC_STATE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ctrlState(ctrlState), .opValid(opValid),
    .aluOverflow(aluOverflow), .strobes(strobes), .excStep(excStep)
  );

  exc_regs #(
    .XLEN(XLEN), .PC_STEP(PC_STEP), .VECTOR(VECTOR)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pcValue(pcValue),
    .pcSrcIn(pcSrcIn), .pcWriteIn(pcWriteIn), .regWriteIn(regWriteIn),
    .pcSrcOut(pcSrcOut), .pcWriteOut(pcWriteOut), .regWriteOut(regWriteOut),
    .vectorAddr(vectorAddr), .epcOut(epcOut), .causeOut(causeOut)
  );

  // R2 / R3: during the step the PC is forced to the vector and writes are squashed
  assert_step_override_R2: assert property (@(posedge clk) disable iff (!rstN)
    excStep |-> (pcSrcOut == 2'b11 && pcWriteOut && !regWriteOut));

  // R7: outside the step the sequencer requests pass unchanged
  assert_passthrough_R7: assert property (@(posedge clk) disable iff (!rstN)
    !excStep |-> (pcSrcOut == pcSrcIn && pcWriteOut == pcWriteIn && regWriteOut == regWriteIn));
endmodule

// File: tb/exc_unit_test.sv
`timescale 1ns/1ps
module exc_unit_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  ctrlState;
  logic        opValid;
  logic        aluOverflow;
  logic [31:0] pcValue;
  logic [1:0]  pcSrcIn;
  logic        pcWriteIn;
  logic        regWriteIn;
  logic [1:0]  pcSrcOut;
  logic        pcWriteOut;
  logic        regWriteOut;
  logic        excStep;
  logic [31:0] vectorAddr;
  logic [31:0] epcOut;
  logic [31:0] causeOut;

  typedef struct { logic [31:0] epc; logic [31:0] cause; } expT;
  expT expQ[$];

  int compared   = 0;
  int mismatched = 0;
  logic [31:0] lastEpc = '0;
  logic [31:0] lastCause = '0;

  always #2.5 clk = ~clk;

  exc_unit uut (
    .clk(clk), .rstN(rstN), .ctrlState(ctrlState), .opValid(opValid),
    .aluOverflow(aluOverflow), .pcValue(pcValue), .pcSrcIn(pcSrcIn),
    .pcWriteIn(pcWriteIn), .regWriteIn(regWriteIn), .pcSrcOut(pcSrcOut),
    .pcWriteOut(pcWriteOut), .regWriteOut(regWriteOut), .excStep(excStep),
    .vectorAddr(vectorAddr), .epcOut(epcOut), .causeOut(causeOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // monitor: pops expected items when the design produces a step
  initial begin
    bit  havePending = 0;
    expT cur;
    forever begin
      @(negedge clk);
      #1;
      if (rstN) begin
        if (havePending) begin
          chk(epcOut == cur.epc, "R4 epc", epcOut, cur.epc);
          chk(causeOut == cur.cause, "R5 cause", causeOut, cur.cause);
          chk(excStep == 1'b0, "R6 single step", {31'b0, excStep}, 32'd0);
          havePending = 0;
        end
        if (excStep) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R8 unexpected step", 32'd1, 32'd0);
          end else begin
            cur = expQ.pop_front();
            chk(pcSrcOut == 2'b11, "R2 pc source vector", {30'b0, pcSrcOut}, 32'd3);
            chk(pcWriteOut == 1'b1, "R2 pc write", {31'b0, pcWriteOut}, 32'd1);
            chk(regWriteOut == 1'b0, "R3 reg write squashed", {31'b0, regWriteOut}, 32'd0);
            havePending = 1;
          end
        end
      end
    end
  end

  // fault in state faultState; step cycle sees stepState/stepOpValid/stepOvf
  task automatic raise(input logic [3:0] faultState, input bit isOvf, input logic [31:0] pcAt,
                       input logic [3:0] stepState, input bit stepOpValid, input bit stepOvf);
    expT e;
    @(negedge clk);
    ctrlState = faultState;
    opValid = isOvf;
    aluOverflow = isOvf;
    pcValue = pcAt;
    pcSrcIn = 2'b00;
    pcWriteIn = 1'b0;
    regWriteIn = 1'b0;
    e.epc = pcAt - 32'd4;
    e.cause = isOvf ? 32'd1 : 32'd0;
    expQ.push_back(e);
    lastEpc = e.epc;
    lastCause = e.cause;
    @(negedge clk);
    ctrlState = stepState;
    opValid = stepOpValid;
    aluOverflow = stepOvf;
    regWriteIn = 1'b1;
    @(negedge clk);
    ctrlState = 4'd0;
    opValid = 1'b1;
    aluOverflow = 1'b0;
    regWriteIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    finish();
  end

  initial begin
    rstN = 1'b0;
    ctrlState = 4'd0; opValid = 1'b1; aluOverflow = 1'b0; pcValue = '0;
    pcSrcIn = 2'b00; pcWriteIn = 1'b0; regWriteIn = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(epcOut == 32'd0, "R1 epc reset", epcOut, 32'd0);
    chk(causeOut == 32'd0, "R1 cause reset", causeOut, 32'd0);
    chk(excStep == 1'b0, "R1 step reset", {31'b0, excStep}, 32'd0);
    chk(vectorAddr == 32'hC000_0000, "R9 vector", vectorAddr, 32'hC000_0000);
    @(negedge clk);
    rstN = 1'b1;

    // R7 passthrough
    @(negedge clk);
    ctrlState = 4'd3; pcSrcIn = 2'b10; pcWriteIn = 1'b1; regWriteIn = 1'b1;
    #2;
    chk(pcSrcOut == 2'b10, "R7 pc source", {30'b0, pcSrcOut}, 32'd2);
    chk(pcWriteOut == 1'b1, "R7 pc write", {31'b0, pcWriteOut}, 32'd1);
    chk(regWriteOut == 1'b1, "R7 reg write", {31'b0, regWriteOut}, 32'd1);

    // R8 fault flags in the wrong states
    @(negedge clk);
    ctrlState = 4'd0; opValid = 1'b0; aluOverflow = 1'b1; pcValue = 32'h100;
    pcSrcIn = 2'b01; pcWriteIn = 1'b0; regWriteIn = 1'b1;
    @(negedge clk);
    #2;
    chk(excStep == 1'b0, "R8 state 0 ignored", {31'b0, excStep}, 32'd0);
    chk(pcSrcOut == 2'b01, "R8 pc source untouched", {30'b0, pcSrcOut}, 32'd1);
    ctrlState = 4'd1; opValid = 1'b1; aluOverflow = 1'b1;
    @(negedge clk);
    #2;
    chk(excStep == 1'b0, "R8 overflow in decode ignored", {31'b0, excStep}, 32'd0);
    ctrlState = 4'd6; opValid = 1'b0; aluOverflow = 1'b0;
    @(negedge clk);
    #2;
    chk(excStep == 1'b0, "R8 bad opcode in execute ignored", {31'b0, excStep}, 32'd0);
    chk(epcOut == 32'd0, "R8 epc unchanged", epcOut, 32'd0);
    chk(causeOut == 32'd0, "R8 cause unchanged", causeOut, 32'd0);
    ctrlState = 4'd0; opValid = 1'b1; regWriteIn = 1'b0;

    // R2 undefined opcode
    raise(4'd1, 1'b0, 32'h0040_0024, 4'd0, 1'b1, 1'b0);
    // R3 overflow; step cycle has R-type completion with write requested
    raise(4'd6, 1'b1, 32'h0040_1000, 4'd7, 1'b1, 1'b0);
    // R4 wrap at PC zero, undefined opcode
    raise(4'd1, 1'b0, 32'h0000_0000, 4'd0, 1'b1, 1'b0);
    // R6 fault presented during the step itself is not taken
    raise(4'd6, 1'b1, 32'h0000_2000, 4'd1, 1'b0, 1'b0);

    // R10 registers hold while idle
    repeat (4) @(negedge clk);
    #2;
    chk(epcOut == lastEpc, "R10 epc hold", epcOut, lastEpc);
    chk(causeOut == lastCause, "R10 cause hold", causeOut, lastCause);
    chk(vectorAddr == 32'hC000_0000, "R9 vector after use", vectorAddr, 32'hC000_0000);
    chk(expQ.size() == 0, "R2 all expected steps seen", expQ.size(), 32'd0);
    finish();
  end
endmodule